// File: doc/BRIEF.md
# Sub-Dword Configuration Write Emulator

This block sits between a front-end request port that issues byte, word and dword configuration accesses and a backend that can only perform full 32-bit reads and writes. Each front-end request carries a byte offset, a size code, an operation code, a data value and, for masked updates, a bit mask. The block turns each request into the smallest backend sequence that can carry it out. A full-dword write becomes a single backend write. A read of any size becomes one backend read. The lane of interest is then shifted down to bit 0. Every other write or masked update becomes a read of the containing dword, a merge in the correct byte lanes, and a write of the merged dword back.

The command/status dword holds status bits in its upper half that clear when a 1 is written to them. A merged write-back could copy a status bit that reads as 1 back into the register and clear it by accident. When the protection parameter is set, any merged write-back to that dword forces the upper half to zero, except for the bytes that the request itself addresses. Misaligned word and dword requests, and undefined size or operation codes, are refused with an error status and never reach the backend. One request is handled at a time. The block reports busy from acceptance until its single completion pulse.

Top module: `cfg_lane_bridge`

## Requirements
- R1: A write (op code 1) of size dword (size code 2) at an aligned offset makes exactly one backend write of the request data and no backend read.
- R2: A byte (size 0) or word (size 1) write, or a masked update (op code 2) of any size, makes exactly one backend read and then one backend write. Both use the same dword address, offset[7:2].
- R3: Byte lanes are little endian. A byte at offset lane k (offset[1:0]) occupies bits 8k+7..8k, and a word at lane 0 or 2 occupies bits 8k+15..8k. After a byte or word write, all bits outside the addressed lanes keep their previous values, except as stated in R7.
- R4: A read (op code 0) makes one backend read and no write. It returns the addressed byte or word shifted down to bit 0 and zero-extended, or the whole dword for size 2.
- R5: A word at an odd offset, a dword at an offset not a multiple of 4, size code 3 and op code 3 all complete with the error flag set and make no backend access.
- R6: A masked update changes only the bits selected by the lane-local mask (shifted to the addressed lane and limited to the lanes of the size). Those bits take the value of the matching data bits. All other bits keep their previous values.
- R7: With protection enabled, a merged write-back (R2) to dword address 1 (offset 0x04) writes zero into bits 31..16, except in the bytes that the request addresses. Write-backs to other dword addresses are not altered.
- R8: busy rises in the cycle after a request is accepted and stays high until the completion pulse. A request presented while busy is ignored and makes no backend access.
- R9: Each accepted request produces exactly one single-cycle done pulse. done_err is low on every successful completion.
- R10: After reset, busy, be_req and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 read, 1 write, 2 masked update |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_offset | input | OFFS_W | Byte offset of the access |
| req_data | input | 32 | Write data, lane-local (bit 0 = first addressed bit) |
| req_mask | input | 32 | Update mask, lane-local |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Completion carries an error |
| done_rdata | output | 32 | Read result, valid with done |
| be_req | output | 1 | Backend access request, held until acknowledged |
| be_we | output | 1 | Backend access is a write |
| be_addr | output | OFFS_W-2 | Backend dword address |
| be_wdata | output | 32 | Backend write data |
| be_ack | input | 1 | Backend acknowledge |
| be_rdata | input | 32 | Backend read data, valid with be_ack |

## Verification
The bench sweeps every offset in the first four dwords against every size and operation code. This covers every lane position, every misalignment and both undefined codes, and it includes the protected dword. A wrong lane shift would corrupt a neighbouring byte in the backend memory model. A missing alignment check would show up as a backend access or a clear error flag. Protection applied in the wrong place would wipe status bits in an unprotected dword, or keep them in the protected one. A request injected while busy checks that a block accepting work mid-sequence would write a dword that should stay untouched.

// File: rtl/cfg_lane_pkg.sv
package cfg_lane_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RESP} lane_state_e;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_WRITE  = 2'd1;
    localparam logic [1:0] OP_MODIFY = 2'd2;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    localparam logic [31:0] STATUS_HALF = 32'hFFFF_0000;
endpackage

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
    import cfg_lane_pkg::*;
(
    input  logic [1:0] op,
    input  logic [1:0] size,
    input  logic [1:0] lane,
    output logic       bad
);
    always_comb begin
        bad = 1'b0;
        if (op == 2'd3)                          bad = 1'b1;
        if (size == 2'd3)                        bad = 1'b1;
        if (size == SZ_WORD && lane[0])          bad = 1'b1;
        if (size == SZ_DWORD && lane != 2'd0)    bad = 1'b1;
    end
endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
    import cfg_lane_pkg::*;
(
    input  logic [31:0] old_val,
    input  logic [31:0] new_data,
    input  logic [31:0] new_mask,
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic        masked,
    input  logic        prot_hit,
    output logic [31:0] merged,
    output logic [31:0] rd_ext
);
    logic [4:0]  sh;
    logic [31:0] lane_bits;
    logic [31:0] sel;
    logic [31:0] raw;
    logic [31:0] shifted;

    always_comb begin
        sh = {lane, 3'b000};
        case (size)
            SZ_BYTE: lane_bits = 32'h0000_00FF << sh;
            SZ_WORD: lane_bits = 32'h0000_FFFF << sh;
            default: lane_bits = 32'hFFFF_FFFF;
        endcase
        sel = masked ? ((new_mask << sh) & lane_bits) : lane_bits;
        raw = (old_val & ~sel) | ((new_data << sh) & sel);
        merged = prot_hit ? (raw & ~(STATUS_HALF & ~lane_bits)) : raw;

        shifted = old_val >> sh;
        case (size)
            SZ_BYTE: rd_ext = {24'd0, shifted[7:0]};
            SZ_WORD: rd_ext = {16'd0, shifted[15:0]};
            default: rd_ext = old_val;
        endcase
    end
endmodule

// File: rtl/cfg_lane_bridge.sv
module cfg_lane_bridge
    import cfg_lane_pkg::*;
#(
    parameter int          OFFS_W     = 8,
    parameter bit          PROTECT_EN = 1'b1,
    parameter int          W1C_DWORD  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [31:0]       req_data,
    input  logic [31:0]       req_mask,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic [31:0]       done_rdata,
    output logic              be_req,
    output logic              be_we,
    output logic [OFFS_W-3:0] be_addr,
    output logic [31:0]       be_wdata,
    input  logic              be_ack,
    input  logic [31:0]       be_rdata
);
    localparam int IDX_W = OFFS_W - 2;

    typedef struct packed {
        lane_state_e      st;
        logic [1:0]       op;
        logic [1:0]       size;
        logic [1:0]       lane;
        logic [IDX_W-1:0] addr;
        logic [31:0]      data;
        logic [31:0]      mask;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
        logic             err;
    } regs_t;

    regs_t       r_q, r_d;
    logic        bad;
    logic        prot_hit;
    logic [31:0] merged;
    logic [31:0] rd_ext;

    cfg_lane_align u_align (
        .op   (req_op),
        .size (req_size),
        .lane (req_offset[1:0]),
        .bad  (bad)
    );

    generate
        if (PROTECT_EN) begin : g_prot
            assign prot_hit = (r_q.addr == W1C_DWORD[IDX_W-1:0]);
        end else begin : g_noprot
            assign prot_hit = 1'b0;
        end
    endgenerate

    cfg_lane_merge u_merge (
        .old_val  (be_rdata),
        .new_data (r_q.data),
        .new_mask (r_q.mask),
        .size     (r_q.size),
        .lane     (r_q.lane),
        .masked   (r_q.op == OP_MODIFY),
        .prot_hit (prot_hit),
        .merged   (merged),
        .rd_ext   (rd_ext)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op    = req_op;
                    r_d.size  = req_size;
                    r_d.lane  = req_offset[1:0];
                    r_d.addr  = req_offset[OFFS_W-1:2];
                    r_d.data  = req_data;
                    r_d.mask  = req_mask;
                    r_d.err   = bad;
                    r_d.rdata = 32'd0;
                    if (bad) begin
                        r_d.st = ST_RESP;
                    end else if (req_op == OP_WRITE && req_size == SZ_DWORD) begin
                        r_d.wdata = req_data;
                        r_d.st    = ST_WR;
                    end else begin
                        r_d.st = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (be_ack) begin
                    if (r_q.op == OP_READ) begin
                        r_d.rdata = rd_ext;
                        r_d.st    = ST_RESP;
                    end else begin
                        r_d.wdata = merged;
                        r_d.st    = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (be_ack) r_d.st = ST_RESP;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = (r_q.st == ST_RESP);
    assign done_err   = done && r_q.err;
    assign done_rdata = r_q.rdata;
    assign be_req     = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign be_we      = (r_q.st == ST_WR);
    assign be_addr    = r_q.addr;
    assign be_wdata   = r_q.wdata;
endmodule

// File: rtl/cfg_lane_bridge_chk.sv
module cfg_lane_bridge_chk #(
    parameter int OFFS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              done_err,
    input logic              be_req,
    input logic              be_we,
    input logic [OFFS_W-3:0] be_addr,
    input logic              be_ack
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_we)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!be_req && !done));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_err_no_backend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> $past(!be_req));
endmodule

bind cfg_lane_bridge cfg_lane_bridge_chk #(.OFFS_W(OFFS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .done_err  (done_err),
    .be_req    (be_req),
    .be_we     (be_we),
    .be_addr   (be_addr),
    .be_ack    (be_ack)
);

// File: tb/cfg_lane_bridge_tb.sv
module cfg_lane_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OFFS_W     = 8;
    localparam int NDW        = 1 << (OFFS_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [1:0]        req_size = '0;
    logic [OFFS_W-1:0] req_offset = '0;
    logic [31:0]       req_data = '0;
    logic [31:0]       req_mask = '0;
    logic              busy, done, done_err;
    logic [31:0]       done_rdata;
    logic              be_req, be_we;
    logic [OFFS_W-3:0] be_addr;
    logic [31:0]       be_wdata;
    logic              be_ack = 1'b0;
    logic [31:0]       be_rdata = '0;

    logic [31:0] mem    [NDW];
    logic [31:0] shadow [NDW];
    int n_rd = 0, n_wr = 0, n_done = 0;
    int errors = 0, checks = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_lane_bridge #(.OFFS_W(OFFS_W), .PROTECT_EN(1'b1), .W1C_DWORD(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_offset(req_offset), .req_data(req_data),
        .req_mask(req_mask), .busy(busy), .done(done), .done_err(done_err),
        .done_rdata(done_rdata), .be_req(be_req), .be_we(be_we),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack),
        .be_rdata(be_rdata)
    );

    // Backend model: acknowledges each access one cycle after it appears.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) n_done <= n_done + 1;
        if (be_req && !be_ack) begin
            be_ack   <= 1'b1;
            be_rdata <= mem[be_addr];
            if (be_we) begin
                mem[be_addr] <= be_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end else begin
            be_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [1:0] sz,
                          input logic [7:0] off, input logic [31:0] dat,
                          input logic [31:0] msk);
        int idx = int'(off[7:2]);
        int sh  = 8 * int'(off[1:0]);
        logic [31:0] old = shadow[idx];
        logic [31:0] lm, sel, expv, exprd;
        bit bad, plain, rmw;
        int rd0, wr0, dn0, cyc;
        logic got_err;
        logic [31:0] got_rd;
        string mtag;
        lm = (sz == 2'd0) ? (32'hFF << sh) : (sz == 2'd1) ? (32'hFFFF << sh) : 32'hFFFF_FFFF;
        bad = (op == 2'd3) || (sz == 2'd3) || (sz == 2'd1 && off[0]) ||
              (sz == 2'd2 && off[1:0] != 2'd0);
        plain = !bad && op == 2'd1 && sz == 2'd2;
        rmw   = !bad && !plain && op != 2'd0;
        sel   = (op == 2'd2) ? ((msk << sh) & lm) : lm;
        expv  = old;
        if (plain) expv = dat;
        if (rmw) begin
            expv = (old & ~sel) | ((dat << sh) & sel);
            if (idx == 1) expv = expv & ~(32'hFFFF_0000 & ~lm);
        end
        exprd = (sz == 2'd0) ? ((old >> sh) & 32'hFF) :
                (sz == 2'd1) ? ((old >> sh) & 32'hFFFF) : old;
        rd0 = n_rd; wr0 = n_wr; dn0 = n_done;

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_size = sz; req_offset = off;
        req_data = dat; req_mask = msk;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        got_err = done_err;
        got_rd  = done_rdata;
        chk(done === 1'b1, "R9", "done seen", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(n_done - dn0 == 1, "R9", "done pulses", n_done - dn0, 1);
        chk(busy === 1'b0, "R8", "busy after done", {31'd0, busy}, 32'd0);
        if (bad) begin
            chk(got_err === 1'b1, "R5", "error flag", {31'd0, got_err}, 32'd1);
            chk(n_rd == rd0 && n_wr == wr0, "R5", "backend untouched",
                n_rd - rd0 + n_wr - wr0, 0);
        end else begin
            chk(got_err === 1'b0, "R9", "error flag", {31'd0, got_err}, 32'd0);
            if (plain)
                chk(n_rd == rd0 && n_wr == wr0 + 1, "R1", "rd/wr count",
                    (n_rd - rd0) * 16 + (n_wr - wr0), 1);
            else if (rmw)
                chk(n_rd == rd0 + 1 && n_wr == wr0 + 1, "R2", "rd/wr count",
                    (n_rd - rd0) * 16 + (n_wr - wr0), 17);
            else begin
                chk(n_rd == rd0 + 1 && n_wr == wr0, "R4", "rd/wr count",
                    (n_rd - rd0) * 16 + (n_wr - wr0), 16);
                chk(got_rd === exprd, "R4", "read data", got_rd, exprd);
            end
        end
        mtag = (rmw && idx == 1) ? "R7" : (op == 2'd2 && !bad) ? "R6" : "R3";
        chk(mem[idx] === expv, mtag, "dword contents", mem[idx], expv);
        shadow[idx] = expv;
    endtask

    initial begin
        for (int i = 0; i < NDW; i++) begin
            mem[i]    = 32'hF00D_0000 ^ (i * 32'h0101_1357) ^ 32'hC3A5_5A3C;
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0, "R10", "busy in reset", {31'd0, busy}, 32'd0);
        chk(be_req === 1'b0, "R10", "be_req in reset", {31'd0, be_req}, 32'd0);
        chk(done === 1'b0, "R10", "done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && be_req === 1'b0, "R10", "idle after reset",
            {30'd0, busy, be_req}, 32'd0);

        // Protected dword: byte write at lane 0 must clear untouched status half (R7)
        run_op(2'd1, 2'd0, 8'h04, 32'h0000_0077, 32'h0);
        // Unprotected dword: status half preserved (R3)
        run_op(2'd1, 2'd0, 8'h10, 32'h0000_0011, 32'h0);

        // Sweep: every offset of the first four dwords, every size and op code
        for (int off = 0; off < 16; off++)
            for (int sz = 0; sz < 4; sz++)
                for (int op = 0; op < 4; op++) begin
                    int k = off * 16 + sz * 4 + op;
                    // re-seed the status half of dword 1 so R7 stays visible
                    if (off == 4 && sz == 0 && op == 0) begin
                        run_op(2'd1, 2'd2, 8'h04, 32'hBEEF_1234, 32'h0);
                    end
                    run_op(op[1:0], sz[1:0], off[7:0],
                           32'h6B3D_A1C7 ^ (k * 32'h0001_0F0F) ^ (k << 20),
                           32'h5A5A_3C3C ^ (k * 32'h0003_0101));
                end

        // R8: request presented while busy is ignored
        begin
            logic [31:0] keep;
            int wr0;
            keep = shadow[8];
            wr0  = n_wr;
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd1; req_size = 2'd0; req_offset = 8'h01;
            req_data = 32'h0000_0042; req_mask = 32'h0;
            @(negedge clk);
            chk(busy === 1'b1, "R8", "busy after accept", {31'd0, busy}, 32'd1);
            req_op = 2'd1; req_size = 2'd2; req_offset = 8'h20; req_data = 32'h1234_5678;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (12) @(negedge clk);
            chk(mem[8] === keep, "R8", "dword 8 untouched", mem[8], keep);
            chk(n_wr - wr0 == 1, "R8", "single write", n_wr - wr0, 1);
            shadow[0] = (shadow[0] & 32'hFFFF_00FF) | 32'h0000_4200;
            chk(mem[0] === shadow[0], "R3", "lane 1 byte write", mem[0], shadow[0]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule